// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block brings up a downstream programmable device over a three-wire passive serial link. On a start pulse it pulls the active-low configuration request low and holds it long enough to reset the target. It confirms that the target's active-low status line answers by going low, releases the request, waits a short settling time, and then waits for the status line to be released. Only after that does it take bitstream bytes from a valid/ready stream and clock them out one bit at a time.

Each byte leaves least significant bit first. Every bit has a low clock phase, during which the data line changes, and then a high phase, on whose rising edge the target captures the bit. After the byte flagged as last, the block checks the target's configuration-done input. It then sends a fixed burst of trailing clock pulses and reports success. If any check fails, the block stops, returns the link to idle and holds a failure code until the next start.

All delays are counted in system clock cycles. They are derived from parameters for the clock frequency, the request hold time in microseconds and the status timeout in microseconds. A further parameter sets the number of system cycles in each serial clock phase.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_req_n_o is 1, ser_clk_o and ser_data_o are 0, busy_o, s_ready_o and success_o are 0, and fail_code_o is 0.
- R2: A start pulse while idle raises busy_o and drives cfg_req_n_o low for strictly more than HOLD_US microseconds of system clock cycles.
- R3: If stat_n_i is high when the request hold ends, the load aborts with fail_code_o = 1 and no serial clock edge is produced.
- R4: After the request is released, the block waits about HOLD_US and then polls stat_n_i for up to TIMEOUT_US. If stat_n_i never goes high in that window, the load aborts with fail_code_o = 2.
- R5: Each accepted byte is sent as 8 bits, least significant bit first, one bit per rising edge of ser_clk_o. ser_data_o does not change while ser_clk_o is high.
- R6: Every high phase of ser_clk_o lasts exactly HALF_CYC system cycles, and every low phase lasts at least HALF_CYC.
- R7: s_ready_o is high only after stat_n_i has been released, and only while no bit is in flight and the byte flagged by s_last_i has not yet been taken. It is low while the request is held and while the serial clock is high.
- R8: If cfg_done_i is low once the last byte has been sent, the load aborts with fail_code_o = 3 and no trailing pulses.
- R9: If cfg_done_i is high once the last byte has been sent, exactly 12 further rising edges appear on ser_clk_o. Then success_o goes to 1 with fail_code_o = 0, and busy_o falls.
- R10: After an abort, cfg_req_n_o is high, ser_clk_o and ser_data_o are low, busy_o is low, and the failure code stays unchanged until the next start, which clears it together with success_o.
- R11: A start pulse while busy_o is high has no effect: cfg_req_n_o falls only once per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (single-cycle pulse, ignored while busy) |
| s_valid_i | input | 1 | Bitstream byte valid |
| s_data_i | input | 8 | Bitstream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Byte accepted when high together with s_valid_i |
| stat_n_i | input | 1 | Target status, active low |
| cfg_done_i | input | 1 | Target configuration complete |
| cfg_req_n_o | output | 1 | Configuration request to target, active low |
| ser_clk_o | output | 1 | Serial configuration clock |
| ser_data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A load is in progress |
| success_o | output | 1 | Last load completed correctly |
| fail_code_o | output | 2 | 0 none, 1 status not asserted, 2 status release timeout, 3 done low after data |

## Verification
A corrupted sequencer state shows up on cfg_req_n_o or s_ready_o within a cycle. Examples are a request pulse that ends early, a second request pulse inside one load, or bytes accepted during the reset handshake. A fault in the serializer shows at the next rising edge of ser_clk_o as a wrong bit or a wrong bit order, or on the next falling edge as a high phase of the wrong length. A miscounted trailing burst or a swapped failure code is only visible when busy_o falls, so every load is checked at that point against the pulse count and code predicted from the target model.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    localparam int BYTE_BITS    = 8;
    localparam int TRAIL_PULSES = 12;
    localparam int SHIFT_W      = (TRAIL_PULSES > BYTE_BITS) ? TRAIL_PULSES : BYTE_BITS;
    localparam int NBITS_W      = $clog2(SHIFT_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETTLE,
        ST_POLL,
        ST_SHIFT,
        ST_CHECK,
        ST_TRAIL
    } cfg_state_e;

    typedef enum logic [1:0] {
        FC_NONE      = 2'd0,
        FC_NO_STATUS = 2'd1,
        FC_TIMEOUT   = 2'd2,
        FC_BOOT      = 2'd3
    } fail_code_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] word;
        logic [NBITS_W-1:0] nbits;
    } shift_cmd_t;

    function automatic int us_to_cycles(input int hz, input int us);
        return (hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/ps_cfg_delay.sv
module ps_cfg_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter
    import ps_cfg_pkg::*;
#(
    parameter int HALF_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  shift_cmd_t cmd_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       sdata_o
);

    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_CYC - 1);

    logic               active_q;
    logic               high_q;
    logic [DW-1:0]      div_q;
    logic [NBITS_W-1:0] left_q;
    logic [SHIFT_W-1:0] sreg_q;
    logic               sclk_q;
    logic               sdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            high_q   <= 1'b0;
            div_q    <= '0;
            left_q   <= '0;
            sreg_q   <= '0;
            sclk_q   <= 1'b0;
            sdata_q  <= 1'b0;
        end else if (!active_q) begin
            if (load_i) begin
                active_q <= 1'b1;
                high_q   <= 1'b0;
                div_q    <= DIV_LAST;
                left_q   <= cmd_i.nbits;
                sreg_q   <= cmd_i.word;
                sdata_q  <= cmd_i.word[0];
                sclk_q   <= 1'b0;
            end
        end else if (div_q != '0) begin
            div_q <= div_q - 1'b1;
        end else if (!high_q) begin
            high_q <= 1'b1;
            sclk_q <= 1'b1;
            div_q  <= DIV_LAST;
        end else begin
            high_q <= 1'b0;
            sclk_q <= 1'b0;
            div_q  <= DIV_LAST;
            left_q <= left_q - 1'b1;
            if (left_q == NBITS_W'(1)) begin
                active_q <= 1'b0;
                sdata_q  <= 1'b0;
            end else begin
                sreg_q  <= sreg_q >> 1;
                sdata_q <= sreg_q[1];
            end
        end
    end

    assign idle_o  = !active_q;
    assign sclk_o  = sclk_q;
    assign sdata_o = sdata_q;

    // R5: the data line holds still across a high clock phase
    p_data_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(sdata_q));

    // R6: an idle serializer never leaves the clock high
    p_idle_clock_low_r6: assert property (@(posedge clk) disable iff (rst)
        (!active_q) |-> !sclk_q);

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int HOLD_US     = 2,
    parameter int TIMEOUT_US  = 100_000,
    parameter int HALF_CYC    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       s_valid_i,
    input  logic [7:0] s_data_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    input  logic       stat_n_i,
    input  logic       cfg_done_i,
    output logic       cfg_req_n_o,
    output logic       ser_clk_o,
    output logic       ser_data_o,
    output logic       busy_o,
    output logic       success_o,
    output logic [1:0] fail_code_o
);

    localparam int HOLD_CYC = us_to_cycles(CLK_FREQ_HZ, HOLD_US) + 1;
    localparam int TMO_CYC  = us_to_cycles(CLK_FREQ_HZ, TIMEOUT_US);
    localparam int MAX_CYC  = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);

    cfg_state_e st_q, st_d;
    fail_code_e code_q, code_d;
    logic       ok_q, ok_d;
    logic       last_q, last_d;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    logic       sh_load;
    shift_cmd_t sh_cmd;
    logic       sh_idle;

    logic ready;
    logic take;

    ps_cfg_delay #(.W(TW)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    ps_cfg_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sh_load),
        .cmd_i   (sh_cmd),
        .idle_o  (sh_idle),
        .sclk_o  (ser_clk_o),
        .sdata_o (ser_data_o)
    );

    assign ready = (st_q == ST_SHIFT) && sh_idle && !last_q;
    assign take  = ready && s_valid_i;

    always_comb begin
        st_d     = st_q;
        code_d   = code_q;
        ok_d     = ok_q;
        last_d   = last_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_cmd   = '0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d     = ST_REQ;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC);
                    code_d   = FC_NONE;
                    ok_d     = 1'b0;
                    last_d   = 1'b0;
                end
            end
            ST_REQ: begin
                if (tmr_exp) begin
                    if (stat_n_i) begin
                        st_d   = ST_IDLE;
                        code_d = FC_NO_STATUS;
                    end else begin
                        st_d     = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HOLD_CYC);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    st_d     = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TMO_CYC);
                end
            end
            ST_POLL: begin
                if (stat_n_i) begin
                    st_d = ST_SHIFT;
                end else if (tmr_exp) begin
                    st_d   = ST_IDLE;
                    code_d = FC_TIMEOUT;
                end
            end
            ST_SHIFT: begin
                if (take) begin
                    sh_load      = 1'b1;
                    sh_cmd.word  = SHIFT_W'(s_data_i);
                    sh_cmd.nbits = NBITS_W'(BYTE_BITS);
                    last_d       = s_last_i;
                end else if (last_q && sh_idle) begin
                    st_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (cfg_done_i) begin
                    st_d         = ST_TRAIL;
                    sh_load      = 1'b1;
                    sh_cmd.word  = '0;
                    sh_cmd.nbits = NBITS_W'(TRAIL_PULSES);
                end else begin
                    st_d   = ST_IDLE;
                    code_d = FC_BOOT;
                end
            end
            ST_TRAIL: begin
                if (sh_idle) begin
                    st_d = ST_IDLE;
                    ok_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            code_q <= FC_NONE;
            ok_q   <= 1'b0;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
            ok_q   <= ok_d;
            last_q <= last_d;
        end
    end

    assign cfg_req_n_o = (st_q != ST_REQ);
    assign busy_o      = (st_q != ST_IDLE);
    assign s_ready_o   = ready;
    assign success_o   = ok_q;
    assign fail_code_o = code_q;

    // Checker state: request low length and trailing pulse count
    logic [TW:0] low_cnt_q;
    logic [3:0]  trail_q;
    logic        sclk_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt_q <= '0;
            trail_q   <= '0;
            sclk_d_q  <= 1'b0;
        end else begin
            low_cnt_q <= cfg_req_n_o ? '0 : low_cnt_q + 1'b1;
            sclk_d_q  <= ser_clk_o;
            if (st_q == ST_CHECK)
                trail_q <= '0;
            else if (ser_clk_o && !sclk_d_q)
                trail_q <= trail_q + 1'b1;
        end
    end

    // R2: the request pulse is never shorter than the hold time
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req_n_o) |-> (low_cnt_q >= (TW+1)'(HOLD_CYC)));

    // R7: bytes are never offered while a bit's high phase is on the wire
    p_ready_clock_low_r7: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (!ser_clk_o && cfg_req_n_o));

    // R9: success follows exactly the fixed trailing burst
    p_trail_count_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> (trail_q == 4'(TRAIL_PULSES)));

    // R10: a held failure code goes with a quiet, idle link
    p_fail_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (code_q != FC_NONE) |-> (cfg_req_n_o && !ser_clk_o && !ser_data_o && !busy_o));

    // R11: a new request pulse only starts from idle
    p_single_request_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_req_n_o) |-> $past(!busy_o));

endmodule

// File: tb/ps_cfg_master_tb_top.sv
module ps_cfg_master_tb_top;

    localparam int CLK_HZ  = 10_000_000;
    localparam int HOLD    = 2;
    localparam int TMO     = 50;
    localparam int HALF    = 2;
    localparam int HOLD_C  = (CLK_HZ / 1_000_000) * HOLD;
    localparam int TMO_C   = (CLK_HZ / 1_000_000) * TMO;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       s_valid_i = 1'b0;
    logic [7:0] s_data_i = 8'h00;
    logic       s_last_i = 1'b0;
    logic       s_ready_o;
    logic       stat_n_i = 1'b1;
    logic       cfg_done_i = 1'b1;
    logic       cfg_req_n_o, ser_clk_o, ser_data_o, busy_o, success_o;
    logic [1:0] fail_code_o;

    always #5 clk = ~clk;

    ps_cfg_master #(
        .CLK_FREQ_HZ (CLK_HZ),
        .HOLD_US     (HOLD),
        .TIMEOUT_US  (TMO),
        .HALF_CYC    (HALF)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .s_valid_i   (s_valid_i),
        .s_data_i    (s_data_i),
        .s_last_i    (s_last_i),
        .s_ready_o   (s_ready_o),
        .stat_n_i    (stat_n_i),
        .cfg_done_i  (cfg_done_i),
        .cfg_req_n_o (cfg_req_n_o),
        .ser_clk_o   (ser_clk_o),
        .ser_data_o  (ser_data_o),
        .busy_o      (busy_o),
        .success_o   (success_o),
        .fail_code_o (fail_code_o)
    );

    int errors = 0;
    int checks = 0;
    bit exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Target model: 0 normal, 1 status never asserted, 2 status never released
    int tgt_mode = 0;
    int rel_cnt  = 100;
    always @(negedge clk) begin
        if (rst) begin
            stat_n_i = 1'b1;
        end else if (tgt_mode == 1) begin
            stat_n_i = 1'b1;
        end else if (tgt_mode == 2) begin
            stat_n_i = 1'b0;
        end else if (!cfg_req_n_o) begin
            stat_n_i = 1'b0;
            rel_cnt  = 0;
        end else if (rel_cnt < 30) begin
            rel_cnt++;
        end else begin
            stat_n_i = 1'b1;
        end
    end

    // Monitor: scoreboard of serial bits, phase lengths, request pulses
    bit prev_sclk = 1'b0;
    bit prev_req  = 1'b1;
    int hi_len    = 0;
    int low_len   = 0;
    int last_low  = 0;
    int n_rise    = 0;
    int n_extra   = 0;
    int n_reqfall = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk_o && !prev_sclk) begin
                n_rise++;
                hi_len = 1;
                if (exp_q.size() != 0) begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(ser_data_o == e, "R5 serial bit", int'(ser_data_o), int'(e));
                end else begin
                    n_extra++;
                end
            end else if (ser_clk_o) begin
                hi_len++;
            end
            if (!ser_clk_o && prev_sclk)
                chk(hi_len == HALF, "R6 high phase length", hi_len, HALF);
            if (!cfg_req_n_o) begin
                if (prev_req) n_reqfall++;
                low_len++;
            end else if (!prev_req) begin
                last_low = low_len;
                low_len  = 0;
            end
            prev_sclk = ser_clk_o;
            prev_req  = cfg_req_n_o;
        end
    end

    task automatic run(input int mode, input bit cd, input int n,
                       input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input bit poke, input int exp_code, input string tag);
        logic [7:0] bytes [3];
        int r0, e0, f0, cyc;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        tgt_mode   = mode;
        cfg_done_i = cd;
        repeat (3) @(negedge clk);
        r0 = n_rise; e0 = n_extra; f0 = n_reqfall;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        chk(cfg_req_n_o == 1'b0, "R2 request low", int'(cfg_req_n_o), 0);
        chk(s_ready_o == 1'b0, "R7 no byte during request", int'(s_ready_o), 0);
        if (mode == 0) begin
            for (int i = 0; i < n; i++) begin
                s_valid_i = 1'b1;
                s_data_i  = bytes[i];
                s_last_i  = (i == n - 1);
                while (!s_ready_o && cyc < 5000) begin
                    @(negedge clk);
                    cyc++;
                end
                for (int k = 0; k < 8; k++) exp_q.push_back(bytes[i][k]);
                @(negedge clk);
                cyc++;
                s_valid_i = 1'b0;
                s_last_i  = 1'b0;
                if (poke && i == 0) begin
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                    cyc++;
                end
            end
        end
        while (busy_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        chk(fail_code_o == 2'(exp_code), tag, int'(fail_code_o), exp_code);
        chk(success_o == (exp_code == 0), tag, int'(success_o), int'(exp_code == 0));
        chk(last_low > HOLD_C, "R2 request hold length", last_low, HOLD_C + 1);
        chk(n_reqfall - f0 == 1, "R11 one request per load", n_reqfall - f0, 1);
        chk(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
        chk(cfg_req_n_o && !ser_clk_o && !ser_data_o && !busy_o && !s_ready_o,
            "R10 idle link after load",
            {28'd0, cfg_req_n_o, ser_clk_o, ser_data_o, busy_o}, 8);
        if (exp_code == 0)
            chk(n_extra - e0 == 12, "R9 trailing pulses", n_extra - e0, 12);
        else if (exp_code == 3)
            chk(n_extra - e0 == 0, "R8 no trailing pulses", n_extra - e0, 0);
        else
            chk(n_rise - r0 == 0, "R3 no serial clock on abort", n_rise - r0, 0);
        if (mode == 2)
            chk(cyc >= 2 * HOLD_C + TMO_C && cyc <= 2 * HOLD_C + TMO_C + 20,
                "R4 timeout window", cyc, 2 * HOLD_C + TMO_C + 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cfg_req_n_o == 1'b1, "R1 request idle", int'(cfg_req_n_o), 1);
        chk(!ser_clk_o && !ser_data_o, "R1 link idle", int'(ser_clk_o | ser_data_o), 0);
        chk(!busy_o && !s_ready_o, "R1 not busy", int'(busy_o | s_ready_o), 0);
        chk(!success_o && fail_code_o == 2'd0, "R1 no result", int'(fail_code_o), 0);

        run(0, 1'b1, 3, 8'hA5, 8'h3C, 8'h81, 1'b1, 0, "R9 success");
        run(1, 1'b1, 0, 8'h00, 8'h00, 8'h00, 1'b0, 1, "R3 status not asserted");
        repeat (40) @(negedge clk);
        chk(fail_code_o == 2'd1, "R10 code held", int'(fail_code_o), 1);
        run(2, 1'b1, 0, 8'h00, 8'h00, 8'h00, 1'b0, 2, "R4 status timeout");
        run(0, 1'b0, 2, 8'h6E, 8'hF0, 8'h00, 1'b0, 3, "R8 done low");
        run(0, 1'b1, 1, 8'h01, 8'h00, 8'h00, 1'b0, 0, "R10 code cleared by new load");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule